// File: doc/BRIEF.md
# EDID Serial Transmitter

This block sends a display's identification bytes to a host over a one-way, point-to-point serial link. The host supplies a slow strobe, VCLK, on `vclk_in`. The block brings that strobe into the system clock domain through a two-flop synchronizer and advances its serial output once on each detected rising edge. The block never receives anything. The data line is either driven with a data bit or released, with `sda_oe` low.

Before transmission, software fills an internal 256-byte buffer:

1. Clear `tx_en`.
2. Raise `sw_access`.
3. Set the pointer with `addr_load`/`addr_value`.
4. Write bytes with `wr_stb`/`wr_data`. Each write post-increments the pointer inside the active region.
5. Drop `sw_access`.
6. Reload the pointer to the first byte to send.
7. Set `tx_en`.

`size_big` selects the active region: bytes 0..127 when low, the whole buffer when high. The same pointer serves as the transmit address. It advances at the start of each frame and wraps at the end of the region, so the table repeats for as long as `tx_en` stays high.

The sequencer has four states, stepped by synchronized VCLK rising edges:

- IDLE → SYNC when `tx_en` is sampled high.
- SYNC → DATA on the 9th rising edge. The first byte is loaded on this transition.
- DATA → GAP on the 8th edge inside DATA. The interrupt pulses on this transition.
- GAP → DATA on the next edge. The next byte is loaded on this transition.
- Any state → IDLE on any clock where `tx_en` is low.

Top module: `edid_serial_tx`

## Requirements
- R1: After reset, `sda_oe`=0, `irq`=0, `buf_ptr`=0, and the sequencer is in IDLE.
- R2: After `tx_en` rises, the first 9 VCLK rising edges form a sync phase, and `sda_oe` stays 0 throughout it.
- R3: From the 9th edge on, each byte is sent MSB first. Bit i+1 replaces bit i on the next edge, and `sda_oe`=1 for all 8 bit periods. A VCLK rise sampled at clock edge n shows on the outputs after clock edge n+2.
- R4: The 9th period of every frame releases the line (`sda_oe`=0).
- R5: `irq` is high for exactly one system clock at the start of each frame's 9th period. It is low at all other times.
- R6: Each frame sends `buffer[buf_ptr]`, and the pointer advances at that moment. The pointer wraps to 0 after 127 when `size_big`=0, and after 255 when `size_big`=1.
- R7: With `sw_access`=1 and `tx_en`=0, a `wr_stb` stores `wr_data` at `buf_ptr`. It then advances the pointer, wrapping at the end of the region.
- R8: With `size_big`=0 and the pointer in 128..255, a write stores its byte but leaves the pointer unchanged. A frame sent from such a pointer sends that byte and then continues from 0.
- R9: A `wr_stb` while `sw_access`=0 or `tx_en`=1 changes neither the buffer nor the pointer.
- R10: Dropping `tx_en` returns the block to IDLE on the next clock, with `sda_oe`=0. The next enable restarts the 9-edge sync phase.
- R11: `addr_load` sets `buf_ptr` to `addr_value`. It takes priority over any advance in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmission enable |
| size_big | input | 1 | Region select: 0 = 128 bytes, 1 = 256 bytes |
| sw_access | input | 1 | Software buffer access enable |
| addr_load | input | 1 | Load the pointer from `addr_value` |
| addr_value | input | 8 | New pointer value |
| wr_stb | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Buffer write data |
| vclk_in | input | 1 | Asynchronous serial clock strobe from the host |
| sda_out | output | 1 | Serial data; 1 when released |
| sda_oe | output | 1 | Data line output enable |
| irq | output | 1 | One-clock pulse at each frame's 9th period |
| buf_ptr | output | 8 | Current buffer pointer |

## Verification
The hardest situation to reach is a transmit pointer crossing a region boundary. Walking there from pointer 0 would take over a thousand VCLK edges. The stimulus instead preloads the pointer to 126, 254 or 200 through `addr_load` before enabling, so the wrap and the out-of-region case each happen within a few frames. A disable in the middle of a frame, followed by re-enable, checks that the sync phase restarts. A behavioural model counts edges since enable and compares against the outputs on every clock.

// File: rtl/edid_tx_pkg.sv
package edid_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_GAP
    } tx_state_e;
endpackage

// File: rtl/vclk_edge_sync.sv
module vclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vclk_async,
    output logic rise
);
    // pipe[STAGES-1] is the synchronized level; pipe[STAGES] is its delayed copy
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], vclk_async};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/edid_byte_store.sv
module edid_byte_store #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int SMALL_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              size_big,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_value,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr,
    output logic [DATA_W-1:0] cur_byte
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] BIG_LAST   = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] SMALL_LAST = ADDR_W'(SMALL_DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] last;
    logic [ADDR_W-1:0] step;
    logic              in_region;

    always_comb begin
        last      = size_big ? BIG_LAST : SMALL_LAST;
        in_region = size_big | ({1'b0, ptr} < (ADDR_W+1)'(SMALL_DEPTH));
        step      = (ptr == last) ? '0 : ptr + 1'b1;
        cur_byte  = mem[ptr];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[ptr] <= wr_data;
    end

    // Priority: explicit load, then transmit advance, then write post-increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ptr <= '0;
        else if (addr_load) ptr <= addr_value;
        else if (adv)       ptr <= in_region ? step : '0;
        else if (wr_en)     ptr <= in_region ? step : ptr;
    end

    // R6: transmit advance from the region's last byte lands on zero
    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !addr_load && ptr == last) |=> (ptr == '0));

    // R8: small region, out-of-region write keeps the pointer
    a_r8_hold_out_of_region: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !adv && !addr_load && !size_big && ptr > SMALL_LAST) |=> $stable(ptr));

    // R11: a load wins over everything else
    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (ptr == $past(addr_value)));
endmodule

// File: rtl/edid_frame_fsm.sv
module edid_frame_fsm
    import edid_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SYNC_EDGES = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rise,
    input  logic [DATA_W-1:0] cur_byte,
    output logic              adv,
    output logic              sda_out,
    output logic              sda_oe,
    output logic              irq
);
    localparam int CNT_MAX = (SYNC_EDGES > DATA_W) ? SYNC_EDGES : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    tx_state_e         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              sync_last, bit_last;

    assign sync_last = (cnt == CNT_W'(SYNC_EDGES - 1));
    assign bit_last  = (cnt == CNT_W'(DATA_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (!tx_en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_SYNC;
                ST_SYNC: if (rise && sync_last) nxt = ST_DATA;
                ST_DATA: if (rise && bit_last)  nxt = ST_GAP;
                ST_GAP:  if (rise)              nxt = ST_DATA;
            endcase
        end
    end

    assign adv = tx_en && rise &&
                 ((state == ST_SYNC && sync_last) || state == ST_GAP);

    // edge counter, shifter and interrupt pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (!tx_en) begin
                cnt <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: cnt <= '0;
                    ST_SYNC: if (rise) begin
                        if (sync_last) begin
                            cnt   <= '0;
                            shreg <= cur_byte;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: if (rise) begin
                        if (bit_last) begin
                            cnt <= '0;
                            irq <= 1'b1;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            shreg <= {shreg[DATA_W-2:0], 1'b0};
                        end
                    end
                    ST_GAP: if (rise) shreg <= cur_byte;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe  = (state == ST_DATA);
        sda_out = sda_oe ? shreg[DATA_W-1] : 1'b1;
    end

    // R10: disable forces idle on the next clock
    a_r10_idle_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (state == ST_IDLE));

    // R5: interrupt lasts one clock
    a_r5_irq_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5: interrupt only follows the last data bit
    a_r5_irq_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(state) == ST_DATA && state == ST_GAP));

    // R3: a driven bit holds between strobe edges
    a_r3_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && tx_en && !rise) |=> $stable(sda_out));
endmodule

// File: rtl/edid_serial_tx.sv
module edid_serial_tx #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int SMALL_DEPTH = 128,
    parameter int SYNC_EDGES  = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              size_big,
    input  logic              sw_access,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_value,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vclk_in,
    output logic              sda_out,
    output logic              sda_oe,
    output logic              irq,
    output logic [ADDR_W-1:0] buf_ptr
);
    logic              rise;
    logic              adv;
    logic              wr_en;
    logic [DATA_W-1:0] cur_byte;

    // software writes only while transmission is stopped
    assign wr_en = wr_stb & sw_access & ~tx_en;

    vclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .vclk_async (vclk_in),
        .rise       (rise)
    );

    edid_byte_store #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .SMALL_DEPTH (SMALL_DEPTH)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .size_big   (size_big),
        .addr_load  (addr_load),
        .addr_value (addr_value),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .adv        (adv),
        .ptr        (buf_ptr),
        .cur_byte   (cur_byte)
    );

    edid_frame_fsm #(
        .DATA_W     (DATA_W),
        .SYNC_EDGES (SYNC_EDGES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .rise     (rise),
        .cur_byte (cur_byte),
        .adv      (adv),
        .sda_out  (sda_out),
        .sda_oe   (sda_oe),
        .irq      (irq)
    );

    // R9: a blocked write leaves the pointer alone
    a_r9_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_en && !adv && !addr_load) |=> $stable(buf_ptr));
endmodule

// File: tb/sim_edid_serial_tx.sv
module sim_edid_serial_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, size_big = 1'b0, sw_access = 1'b0;
    logic       addr_load = 1'b0, wr_stb = 1'b0, vclk = 1'b0;
    logic [7:0] addr_value = '0, wr_data = '0;
    logic       sda_out, sda_oe, irq;
    logic [7:0] buf_ptr;

    int checks = 0;
    int fails  = 0;
    int irq_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;

    edid_serial_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .size_big(size_big),
        .sw_access(sw_access), .addr_load(addr_load), .addr_value(addr_value),
        .wr_stb(wr_stb), .wr_data(wr_data), .vclk_in(vclk),
        .sda_out(sda_out), .sda_oe(sda_oe), .irq(irq), .buf_ptr(buf_ptr)
    );

    // ---------------- reference model ----------------
    logic [7:0] mmem [256];
    bit         vq[$] = '{0, 0, 0, 0};
    bit         active = 0;
    int         edges = 0;
    int         mptr = 0;
    logic [7:0] cur = '0;
    bit         e_oe = 0, e_irq = 0, e_bit = 1;
    string      phase = "R1";

    function automatic int m_last();
        return size_big ? 255 : 127;
    endfunction
    function automatic bit m_inreg(int p);
        return size_big || p < 128;
    endfunction
    function automatic int m_step(int p);
        return (p == m_last()) ? 0 : p + 1;
    endfunction

    always @(posedge clk) begin
        bit rise_m;
        vq.push_back(vclk);
        void'(vq.pop_front());
        rise_m = (vq[1] == 1'b1) && (vq[0] == 1'b0);
        if (!rst_n) begin
            active = 0; edges = 0; mptr = 0; e_oe = 0; e_irq = 0; phase = "R1";
        end else begin
            e_irq = 0;
            if (!tx_en) begin
                active = 0; e_oe = 0; phase = "R10";
            end else if (!active) begin
                active = 1; edges = 0; e_oe = 0; phase = "R2";
            end else if (rise_m) begin
                edges++;
                if (edges >= 9) begin
                    int k, pos;
                    k = edges - 9;
                    pos = k % 9;
                    if (pos == 0) begin
                        cur = mmem[mptr];
                        mptr = m_inreg(mptr) ? m_step(mptr) : 0;
                        e_oe = 1; e_bit = cur[7]; phase = "R3";
                    end else if (pos < 8) begin
                        e_oe = 1; e_bit = cur[7-pos]; phase = "R3";
                    end else begin
                        e_oe = 0; e_irq = 1; phase = "R4";
                    end
                end
            end
            if (addr_load) mptr = addr_value;
            else if (wr_stb && sw_access && !tx_en) begin
                mmem[mptr] = wr_data;
                if (m_inreg(mptr)) mptr = m_step(mptr);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison, away from the edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk(phase, sda_oe, e_oe);
            chk("R5", irq, e_irq);
            chk(active ? "R6" : "R7", buf_ptr, mptr);
            if (e_oe) chk("R3", sda_out, e_bit);
            if (irq) irq_seen++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_load(int a);
        @(negedge clk); addr_load = 1; addr_value = 8'(a);
        @(negedge clk); addr_load = 0;
    endtask
    task automatic do_write(int d);
        @(negedge clk); wr_stb = 1; wr_data = 8'(d);
        @(negedge clk); wr_stb = 0;
    endtask
    task automatic vpulse(int n);
        repeat (n) begin
            vclk = 1; tick(4);
            vclk = 0; tick(4);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk("R1", buf_ptr, 0);
        chk("R1", sda_oe, 0);
        chk("R1", irq, 0);

        // R7: fill the full buffer, pointer wraps after 255
        size_big = 1; sw_access = 1;
        do_load(0);
        for (int i = 0; i < 256; i++) do_write((i * 37 + 5) & 8'hff);
        tick(1);
        chk("R7", buf_ptr, 0);

        // R8: small region, out-of-region write holds pointer
        size_big = 0;
        do_load(200);
        do_write(8'hA5);
        tick(1);
        chk("R8", buf_ptr, 200);
        // R7: small region wrap after 127
        do_load(127);
        do_write(8'h3C);
        tick(1);
        chk("R7", buf_ptr, 0);

        // R9: write without software access ignored
        sw_access = 0;
        do_write(8'hFF);
        tick(1);
        chk("R9", buf_ptr, 0);

        // R6: transmit across the small-region wrap: 126,127,0,1
        do_load(126);
        tick(1);
        chk("R11", buf_ptr, 126);
        irq_seen = 0;
        tx_en = 1;
        tick(2);
        vpulse(44);
        tick(2);
        chk("R5", irq_seen, 4);
        chk("R6", buf_ptr, 2);

        // R10: disable mid-frame, then re-enable restarts sync
        tx_en = 0; tick(2);
        tx_en = 1; tick(2);
        vpulse(12);
        tx_en = 0; tick(2);
        chk("R10", sda_oe, 0);
        chk("R10", buf_ptr, 3);
        tx_en = 1; tick(2);
        vpulse(5);
        chk("R10", sda_oe, 0);
        // R9: write while enabled ignored
        sw_access = 1;
        do_write(8'h77);
        tick(1);
        chk("R9", buf_ptr, 3);
        sw_access = 0;
        tx_en = 0; tick(2);

        // R6: full-region wrap 254,255,0
        size_big = 1;
        do_load(254);
        irq_seen = 0;
        tx_en = 1; tick(2);
        vpulse(35);
        tick(2);
        chk("R6", buf_ptr, 1);
        chk("R5", irq_seen, 3);
        tx_en = 0; tick(2);

        // R8: transmit from out-of-region pointer, then restart at 0
        size_big = 0;
        do_load(200);
        tx_en = 1; tick(2);
        vpulse(19);
        tick(2);
        chk("R8", buf_ptr, 1);
        tx_en = 0; tick(4);
        chk("R10", sda_oe, 0);

        finish_run();
    end
endmodule